// File: doc/BRIEF.md
# USB High-Speed Host Chirp Generator

This block sits on the link side of a high-speed USB host port and runs the host's half of the bus-reset speed handshake. When a reset is requested it drives SE0 onto the bus and switches the transceiver operating mode to its raw, non-stuffing setting. While SE0 is held it watches the 2-bit line state for the attached device's Chirp K. A K only counts once it has stayed on the line without a break for at least 2.5 µs. A shorter blip restarts the qualification and leaves the bus in SE0.

Once a valid device K has been seen and the line leaves the K state, the block raises its transmit request on the next clock edge. The transmit request stands for a no-PID transmit command. The block then sends host chirps that alternate K and J. Each symbol is held for a fixed number of microsecond ticks (50 by default, inside the 40 to 60 µs window). The sequence stops after a configured number of K/J pairs or at the end of the reset window, whichever comes first. A symbol that has started always runs to its end. The block then drops the request and returns the operating mode to normal so that high-speed packets can follow. If no device chirp is qualified, SE0 is held for the whole reset window.

Timing uses two inputs. A one-cycle microsecond tick times the reset window and the chirp symbols. A clock-cycles-per-microsecond parameter sizes the 2.5 µs qualification filter in clock cycles.

Top module: `hs_host_chirp`

## Requirements
- R1: After synchronous reset the outputs are `chirp_sym`=00 (bus released), `tx_req`=0 and `opmode`=00.
- R2: A `reset_start` pulse while idle makes `chirp_sym`=01 (drive SE0) and `opmode`=10 from the next edge. If no device chirp is qualified, both are held until the RESET_US-th tick after that edge, at which point `chirp_sym` returns to 00 and `opmode` to 00.
- R3: A device Chirp K (`line_state`=10) qualifies only after ceil(2.5·CYC_PER_US) consecutive K samples while SE0 is driven. A shorter K is discarded, the count restarts, and no chirp follows.
- R4: After qualification, the first edge that samples `line_state` other than 10 starts the host chirp: `tx_req`=1 and `chirp_sym`=10 (Chirp K) from that edge, well inside the 100 µs response limit.
- R5: Host symbols alternate Chirp K (`chirp_sym`=10) and Chirp J (`chirp_sym`=11), starting with K. Each symbol lasts CHIRP_US microsecond ticks, which is between 40 and 60 µs.
- R6: After NUM_PAIRS K/J pairs the sequence ends at the end of a J. On that edge `tx_req`=0, `chirp_sym`=00 and `opmode`=00.
- R7: If the reset window ends in the middle of a symbol, that symbol still completes and is the last one sent. The sequence may therefore end on a K.
- R8: If the reset window ends on the same edge on which a symbol ends, no further symbol is started.
- R9: `reset_start` is ignored while a reset or chirp sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_start | input | 1 | One-cycle request to begin a bus reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| tx_req | output | 1 | No-PID transmit command active (host chirp in progress) |
| chirp_sym | output | 2 | Bus drive: 00 released, 01 SE0, 10 Chirp K, 11 Chirp J |
| opmode | output | 2 | Transceiver operating mode: 10 during reset/chirp, 00 normal |

## Verification
Two events can land on the same edge: the expiry of the reset window and the end of a chirp symbol. The bench provokes this by releasing the device K exactly 100 ticks before the window expires. The second symbol (a J) then ends on the expiry tick. The scoreboard must see exactly K then J, and the bus must be released on that edge, with no third symbol started. A second run releases the K 125 ticks before expiry, which makes the expiry fall inside a K. That K must run to its full length and be the last symbol sent.

// File: rtl/hs_host_chirp_pkg.sv
package hs_host_chirp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        DRV_OFF = 2'b00,
        DRV_SE0 = 2'b01,
        DRV_K   = 2'b10,
        DRV_J   = 2'b11
    } drive_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SE0,
        ST_KHOLD,
        ST_CHIRP
    } ctl_e;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_RAW    = 2'b10;

    // cycles covering 2.5 us, rounded up
    function automatic int qual_cycles(input int cyc_per_us);
        return (5 * cyc_per_us + 1) / 2;
    endfunction

    function automatic drive_e drive_of(input ctl_e st, input logic on_k);
        case (st)
            ST_SE0, ST_KHOLD: return DRV_SE0;
            ST_CHIRP:         return on_k ? DRV_K : DRV_J;
            default:          return DRV_OFF;
        endcase
    endfunction

endpackage

// File: rtl/hs_tick_timer.sv
module hs_tick_timer #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    assign done = run && tick && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= done ? '0 : cnt_q + 1'b1;
    end

    // R5 / R2: the tick count never passes its terminal value
    p_cnt_below_limit_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < W'(LIMIT));

endmodule

// File: rtl/hs_kj_qualifier.sv
module hs_kj_qualifier #(
    parameter int QUAL_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic is_k,
    output logic qual
);
    localparam int W = $clog2(QUAL_CYC + 1);

    logic [W-1:0] run_q;

    assign qual = en && is_k && (run_q == W'(QUAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || !is_k)
            run_q <= '0;
        else if (run_q < W'(QUAL_CYC - 1))
            run_q <= run_q + 1'b1;
    end

    generate
        if (QUAL_CYC > 1) begin : g_multi
            // R3: qualification needs K on the previous sample as well
            p_qual_after_k_r3: assert property (@(posedge clk) disable iff (rst)
                qual |-> $past(is_k && en));
        end
    endgenerate

endmodule

// File: rtl/hs_host_chirp.sv
module hs_host_chirp
    import hs_host_chirp_pkg::*;
#(
    parameter int CYC_PER_US = 60,
    parameter int CHIRP_US   = 50,
    parameter int RESET_US   = 10000,
    parameter int NUM_PAIRS  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reset_start,
    input  logic       us_tick,
    input  logic [1:0] line_state,
    output logic       tx_req,
    output logic [1:0] chirp_sym,
    output logic [1:0] opmode
);
    localparam int K_QUAL = qual_cycles(CYC_PER_US);
    localparam int PW     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

    ctl_e          state_q;
    logic          sym_k_q;
    logic [PW-1:0] pair_q;
    logic          stop_q;
    logic          rst_exp, sym_done, k_qual;
    logic          last_pair;
    drive_e        drv;

    hs_tick_timer #(.LIMIT(RESET_US)) u_win (
        .clk(clk), .rst(rst),
        .clr(state_q == ST_IDLE), .run(state_q != ST_IDLE),
        .tick(us_tick), .done(rst_exp)
    );

    hs_tick_timer #(.LIMIT(CHIRP_US)) u_sym (
        .clk(clk), .rst(rst),
        .clr(state_q != ST_CHIRP), .run(state_q == ST_CHIRP),
        .tick(us_tick), .done(sym_done)
    );

    hs_kj_qualifier #(.QUAL_CYC(K_QUAL)) u_kq (
        .clk(clk), .rst(rst),
        .en(state_q == ST_SE0), .is_k(line_state == LS_K),
        .qual(k_qual)
    );

    assign last_pair = !sym_k_q && (pair_q == PW'(NUM_PAIRS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sym_k_q <= 1'b1;
            pair_q  <= '0;
            stop_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    stop_q <= 1'b0;
                    if (reset_start) state_q <= ST_SE0;
                end
                ST_SE0: begin
                    if (rst_exp)     state_q <= ST_IDLE;
                    else if (k_qual) state_q <= ST_KHOLD;
                end
                ST_KHOLD: begin
                    if (rst_exp) begin
                        state_q <= ST_IDLE;
                    end else if (line_state != LS_K) begin
                        state_q <= ST_CHIRP;
                        sym_k_q <= 1'b1;
                        pair_q  <= '0;
                    end
                end
                default: begin
                    if (rst_exp) stop_q <= 1'b1;
                    if (sym_done) begin
                        if (stop_q || rst_exp || last_pair) begin
                            state_q <= ST_IDLE;
                        end else begin
                            sym_k_q <= !sym_k_q;
                            if (!sym_k_q) pair_q <= pair_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign drv       = drive_of(state_q, sym_k_q);
    assign chirp_sym = drv;
    assign tx_req    = (state_q == ST_CHIRP);
    assign opmode    = (state_q == ST_IDLE) ? MODE_NORMAL : MODE_RAW;

    // R4: the transmit request only ever carries chirp symbols
    p_txreq_sym_r4: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> (chirp_sym == DRV_K || chirp_sym == DRV_J));

    // R5: a symbol changes only on a microsecond tick
    p_sym_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHIRP && $past(state_q) == ST_CHIRP && sym_k_q != $past(sym_k_q))
            |-> $past(us_tick));

    // R6: when the chirp ends the bus is released and the mode is normal
    p_end_normal_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_req) |-> (opmode == MODE_NORMAL && chirp_sym == DRV_OFF));

    // R6: the pair counter stays inside the configured count
    p_pairs_bound_r6: assert property (@(posedge clk) disable iff (rst)
        pair_q <= PW'(NUM_PAIRS - 1));

    // R3: the hold state is entered only from a K sample
    p_khold_from_k_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_KHOLD && $past(state_q) == ST_SE0) |-> $past(line_state) == LS_K);

    // R8: window expiry on a symbol end leaves the chirp
    p_expire_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHIRP && sym_done && rst_exp) |=> state_q == ST_IDLE);

    // R9: a running handshake never falls back into SE0
    p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_KHOLD || state_q == ST_CHIRP) |=> state_q != ST_SE0);

endmodule

// File: tb/hs_host_chirp_test.sv
`timescale 1ns/1ps
module hs_host_chirp_test;

    localparam int CPU    = 4;
    localparam int SYM_US = 50;
    localparam int WIN_US = 600;
    localparam int PAIRS  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reset_start = 1'b0;
    logic [1:0] line_state = 2'b00;
    logic [1:0] div_q;
    logic       us_tick;
    logic       tx_req;
    logic [1:0] chirp_sym;
    logic [1:0] opmode;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;
    logic [1:0] exp_q[$];

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end
    assign us_tick = (div_q == 2'd3);

    hs_host_chirp #(.CYC_PER_US(CPU), .CHIRP_US(SYM_US), .RESET_US(WIN_US),
                    .NUM_PAIRS(PAIRS)) uut (
        .clk(clk), .rst(rst), .reset_start(reset_start), .us_tick(us_tick),
        .line_state(line_state), .tx_req(tx_req), .chirp_sym(chirp_sym),
        .opmode(opmode)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk iff us_tick);
        @(negedge clk);
    endtask

    task automatic do_start();
        wait_ticks(1);
        reset_start = 1'b1;
        @(negedge clk);
        reset_start = 1'b0;
    endtask

    // driver side of the scoreboard: expected chirp symbols, starting with K
    task automatic push_seq(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back((i % 2 == 0) ? 2'b10 : 2'b11);
    endtask

    // monitor side: pops on each new chirp symbol, times each one
    logic [1:0] prev_drv = 2'b00;
    int dur = 0;
    always @(negedge clk) begin
        if (rst) begin
            prev_drv = 2'b00;
            dur = 0;
        end else begin
            dur++;
            if (chirp_sym != prev_drv) begin
                if (prev_drv[1])
                    check(dur >= 40*CPU && dur <= 60*CPU, "R5 symbol length", dur, SYM_US*CPU);
                if (chirp_sym[1]) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5 unexpected symbol", chirp_sym, 0);
                    end else begin
                        logic [1:0] e;
                        e = exp_q.pop_front();
                        check(chirp_sym == e, "R5 symbol order", chirp_sym, e);
                    end
                    check(tx_req == 1'b1, "R4 tx_req with chirp", tx_req, 1);
                end
                dur = 0;
                prev_drv = chirp_sym;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(chirp_sym == 2'b00, "R1 reset drive", chirp_sym, 0);
        check(tx_req == 1'b0, "R1 reset tx_req", tx_req, 0);
        check(opmode == 2'b00, "R1 reset opmode", opmode, 0);

        // scenario 1: no device chirp, SE0 over the whole window
        do_start();
        check(chirp_sym == 2'b01, "R2 SE0 after start", chirp_sym, 1);
        check(opmode == 2'b10, "R2 raw mode after start", opmode, 2);
        wait_ticks(WIN_US - 1);
        check(chirp_sym == 2'b01, "R2 SE0 before window end", chirp_sym, 1);
        check(tx_req == 1'b0, "R2 no tx without chirp", tx_req, 0);
        wait_ticks(1);
        check(chirp_sym == 2'b00, "R2 released at window end", chirp_sym, 0);
        check(opmode == 2'b00, "R2 normal mode at window end", opmode, 0);
        wait_ticks(5);

        // scenario 2: glitch, then a real K, full pair count
        do_start();
        wait_ticks(3);
        line_state = 2'b10;
        wait_ticks(2);
        line_state = 2'b00;
        @(negedge clk);
        @(negedge clk);
        check(chirp_sym == 2'b01, "R3 short K ignored", chirp_sym, 1);
        wait_ticks(2);
        line_state = 2'b10;
        wait_ticks(5);
        push_seq(2 * PAIRS);
        line_state = 2'b00;
        @(negedge clk);
        check(chirp_sym == 2'b10 && tx_req, "R4 chirp starts after K ends", chirp_sym, 2);
        wait_ticks(100);
        reset_start = 1'b1;          // R9: must not disturb the sequence
        @(negedge clk);
        reset_start = 1'b0;
        check(tx_req == 1'b1, "R9 start ignored while busy", tx_req, 1);
        wait_ticks(300);
        check(chirp_sym == 2'b00 && !tx_req, "R6 released after pairs", chirp_sym, 0);
        check(opmode == 2'b00, "R6 normal mode after pairs", opmode, 0);
        check(exp_q.size() == 0, "R6 all symbols sent", exp_q.size(), 0);
        wait_ticks(5);

        // scenario 3: window ends inside a K, that K completes
        do_start();
        line_state = 2'b10;
        wait_ticks(475);
        push_seq(3);
        line_state = 2'b00;
        wait_ticks(149);
        check(chirp_sym == 2'b10, "R7 K runs past window end", chirp_sym, 2);
        wait_ticks(1);
        check(chirp_sym == 2'b00 && !tx_req, "R7 released after last K", chirp_sym, 0);
        check(opmode == 2'b00, "R7 normal mode", opmode, 0);
        check(exp_q.size() == 0, "R7 three symbols sent", exp_q.size(), 0);
        wait_ticks(5);

        // scenario 4: window end and symbol end on the same edge
        do_start();
        line_state = 2'b10;
        wait_ticks(500);
        push_seq(2);
        line_state = 2'b00;
        wait_ticks(99);
        check(chirp_sym == 2'b11, "R8 J before coincident end", chirp_sym, 3);
        wait_ticks(1);
        check(chirp_sym == 2'b00 && !tx_req, "R8 no symbol after coincident end", chirp_sym, 0);
        check(exp_q.size() == 0, "R8 two symbols sent", exp_q.size(), 0);
        wait_ticks(60);
        check(chirp_sym == 2'b00, "R8 bus stays released", chirp_sym, 0);

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule